// File: doc/BRIEF.md
# Host Memory and I/O Address Router with Protected SMM Window

This block sits in the host bridge of a small system-on-chip and sorts every incoming request by address. A memory request may go to DRAM, to one of four fixed legacy regions, or to one of several programmable PCI windows. It may also be refused, or left unclaimed. An I/O request is sorted separately, into the bridge's own configuration-access ports, the general legacy I/O range, or nothing.

One window of low DRAM holds the system-management handler code. A request inside that window is served only when it comes from the processor core and the core is in system management mode. Any other request to the window is refused: a refused read returns all ones, a refused write is dropped, and the block raises a one-cycle violation flag that carries the offending address.

Software sets the protected window, the top of low DRAM and the PCI windows through a simple write port. The hardware performs no overlap checks: a fixed priority settles every conflict. The decode result is registered, so each answer appears on the clock after the request is accepted.

Top module: `memdec_guard`

## Requirements
- R1: After reset, no response and no violation are presented, the protected window and all PCI windows are disabled, and the top of low DRAM is 1000_0000h.
- R2: A memory request whose address lies in the enabled protected window is routed to DRAM (target code 1) and is not blocked, provided the initiator equals CORE_ID (default 0) and the SMM flag is 1.
- R3: Any other request into the enabled protected window is blocked. The response carries target code 7 and blocked=1. A read returns rdata FFFF_FFFFh, the write strobe stays 0, and violation=1 is presented for that one response with the request address.
- R4: The protected window covers addresses whose bits [31:20] lie between the start and end registers, both bounds inclusive. Writes to those registers ignore data bits [19:0].
- R5: The fixed regions take target code 2 and an index: 0 for 000E0000h–000FFFFFh, 1 for FEC00000h–FEC00040h, 2 for FED00000h–FED003FFh and 3 for FFFE0000h–FFFFFFFFh. They win over the PCI windows and over DRAM.
- R6: A memory address claimed by neither the protected window nor a fixed region goes to an enabled PCI window. That window satisfies base[31:12] ≤ addr[31:12] ≤ limit[31:12]. The response carries target code 3, and the index is the lowest-numbered matching window.
- R7: Any other memory address with bits [31:20] below the top-of-low-DRAM register goes to DRAM (code 1). Writes to that register ignore data bits [19:0].
- R8: A memory address that nothing claims gets target code 0, blocked=0 and rdata 0.
- R9: An I/O request (space=1) takes code 5 for 0CF8h–0CFFh and code 4 for any other address up to 10002h. Above 10002h it takes code 0. The protected window never applies to I/O.
- R10: req_ready is always 1. Each accepted request yields rsp_valid=1 on the next clock only. Without a request, rsp_valid is 0 on the next clock.
- R11: rsp_write is 1 exactly for an accepted write that is not blocked. rsp_index is 0 for targets other than 2 and 3.
- R12: Configuration selects are 0 window start, 1 window end, 2 window enable (bit 0), 3 top of low DRAM, 4+2i window i base with its enable in bit 0, and 5+2i window i limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always ready |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_init | input | IDW (3) | Initiator identifier |
| req_smm | input | 1 | Initiator is in system management mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SELW (4) | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| rsp_valid | output | 1 | Decode result valid |
| rsp_target | output | 3 | Target code |
| rsp_index | output | IXW (2) | Fixed-region or PCI window index |
| rsp_blocked | output | 1 | Request refused |
| rsp_write | output | 1 | Forwarded write strobe |
| rsp_rdata | output | 32 | All ones for a refused read, else 0 |
| viol_pulse | output | 1 | Protection violation |
| viol_addr | output | 32 | Address of the refused request |

## Verification
The assertions run on every cycle and check four things. A response follows exactly one clock after each accepted request. A blocked response never traces back to a core request made in SMM, and it never forwards a write. Every violation flag reports the address that was just sent, and an I/O address above the top of the I/O range is never claimed. The priority between overlapping regions, the inclusive 1 MiB bounds of the protected window, the masking of the low bits on writes, and the choice of the lowest-numbered window among overlapping PCI windows depend on the programmed values. Only the bench's sweeps can show those, and it runs them under three different configurations.

// File: rtl/memdec_guard.sv
module memdec_guard #(
  parameter int              IDW      = 3,
  parameter logic [IDW-1:0]  CORE_ID  = '0,
  parameter int              NWIN     = 4,
  parameter logic [31:0]     TOLM_RST = 32'h1000_0000,
  localparam int             SELW     = $clog2(4 + 2*NWIN),
  localparam int             IXW      = (NWIN > 4) ? $clog2(NWIN) : 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_io,
  input  logic [31:0]     req_addr,
  input  logic            req_write,
  input  logic [IDW-1:0]  req_init,
  input  logic            req_smm,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [31:0]     cfg_wdata,
  output logic            rsp_valid,
  output logic [2:0]      rsp_target,
  output logic [IXW-1:0]  rsp_index,
  output logic            rsp_blocked,
  output logic            rsp_write,
  output logic [31:0]     rsp_rdata,
  output logic            viol_pulse,
  output logic [31:0]     viol_addr
);

  localparam logic [2:0] T_NONE   = 3'd0;
  localparam logic [2:0] T_DRAM   = 3'd1;
  localparam logic [2:0] T_LEG    = 3'd2;
  localparam logic [2:0] T_PCI    = 3'd3;
  localparam logic [2:0] T_IOLEG  = 3'd4;
  localparam logic [2:0] T_IOHOST = 3'd5;
  localparam logic [2:0] T_SMBLK  = 3'd7;

  logic [11:0] sm_lo, sm_hi, tolm_hi;
  logic        sm_en;
  logic [19:0] wbase [NWIN];
  logic [19:0] wlim  [NWIN];
  logic [NWIN-1:0] wen;

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata[11:1];

  assign req_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sm_lo   <= '0;
      sm_hi   <= '0;
      sm_en   <= 1'b0;
      tolm_hi <= TOLM_RST[31:20];
      wen     <= '0;
      for (int i = 0; i < NWIN; i++) begin
        wbase[i] <= '0;
        wlim[i]  <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_sel)
        SELW'(0): sm_lo   <= cfg_wdata[31:20];
        SELW'(1): sm_hi   <= cfg_wdata[31:20];
        SELW'(2): sm_en   <= cfg_wdata[0];
        SELW'(3): tolm_hi <= cfg_wdata[31:20];
        default: ;
      endcase
      for (int i = 0; i < NWIN; i++) begin
        if (cfg_sel == SELW'(4 + 2*i)) begin
          wbase[i] <= cfg_wdata[31:12];
          wen[i]   <= cfg_wdata[0];
        end
        if (cfg_sel == SELW'(5 + 2*i)) wlim[i] <= cfg_wdata[31:12];
      end
    end
  end

  wire in_sm = sm_en && req_addr[31:20] >= sm_lo && req_addr[31:20] <= sm_hi;
  wire sm_ok = (req_init == CORE_ID) && req_smm;

  logic [3:0] leg_hit;
  assign leg_hit[0] = req_addr >= 32'h000E_0000 && req_addr <= 32'h000F_FFFF;
  assign leg_hit[1] = req_addr >= 32'hFEC0_0000 && req_addr <= 32'hFEC0_0040;
  assign leg_hit[2] = req_addr >= 32'hFED0_0000 && req_addr <= 32'hFED0_03FF;
  assign leg_hit[3] = req_addr >= 32'hFFFE_0000;

  logic [NWIN-1:0] win_hit;
  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign win_hit[g] = wen[g] && req_addr[31:12] >= wbase[g] && req_addr[31:12] <= wlim[g];
  end

  logic [2:0]     d_tgt;
  logic [IXW-1:0] d_idx;
  logic           d_blk;

  always_comb begin
    d_tgt = T_NONE;
    d_idx = '0;
    d_blk = 1'b0;
    if (req_io) begin
      if (req_addr >= 32'h0CF8 && req_addr <= 32'h0CFF) d_tgt = T_IOHOST;
      else if (req_addr <= 32'h1_0002)                  d_tgt = T_IOLEG;
    end else if (in_sm) begin
      if (sm_ok) d_tgt = T_DRAM;
      else begin
        d_tgt = T_SMBLK;
        d_blk = 1'b1;
      end
    end else if (|leg_hit) begin
      d_tgt = T_LEG;
      for (int i = 3; i >= 0; i--) if (leg_hit[i]) d_idx = IXW'(i);
    end else if (|win_hit) begin
      d_tgt = T_PCI;
      for (int i = NWIN-1; i >= 0; i--) if (win_hit[i]) d_idx = IXW'(i);
    end else if (req_addr[31:20] < tolm_hi) begin
      d_tgt = T_DRAM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_target  <= T_NONE;
      rsp_index   <= '0;
      rsp_blocked <= 1'b0;
      rsp_write   <= 1'b0;
      rsp_rdata   <= '0;
      viol_pulse  <= 1'b0;
      viol_addr   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_target  <= req_valid ? d_tgt : T_NONE;
      rsp_index   <= req_valid ? d_idx : '0;
      rsp_blocked <= req_valid && d_blk;
      rsp_write   <= req_valid && req_write && !d_blk;
      rsp_rdata   <= {32{req_valid && d_blk && !req_write}};
      viol_pulse  <= req_valid && d_blk;
      if (req_valid && d_blk) viol_addr <= req_addr;
    end
  end

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_core_smm_never_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_blocked |-> !($past(req_smm) && $past(req_init) == CORE_ID && !$past(req_io)));
  a_r3_viol_addr: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> rsp_valid && rsp_blocked && viol_addr == $past(req_addr));
  a_r11_no_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_blocked |-> !rsp_write);
  a_r9_io_top: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(req_io) && $past(req_addr) > 32'h1_0002 |-> rsp_target == T_NONE);

endmodule

// File: tb/sim_memdec_guard.sv
`timescale 1ns/1ps
module sim_memdec_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0, req_smm = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_init = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_ready, rsp_valid, rsp_blocked, rsp_write, viol_pulse;
  logic [2:0]  rsp_target;
  logic [1:0]  rsp_index;
  logic [31:0] rsp_rdata, viol_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  memdec_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_io(req_io), .req_addr(req_addr), .req_write(req_write),
    .req_init(req_init), .req_smm(req_smm), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid), .rsp_target(rsp_target),
    .rsp_index(rsp_index), .rsp_blocked(rsp_blocked), .rsp_write(rsp_write),
    .rsp_rdata(rsp_rdata), .viol_pulse(viol_pulse), .viol_addr(viol_addr)
  );

  logic        s_sm_en = 1'b0;
  logic [11:0] s_sm_lo = '0, s_sm_hi = '0, s_tolm = 12'h100;
  logic [19:0] s_wb [4] = '{default: '0};
  logic [19:0] s_wl [4] = '{default: '0};
  logic [3:0]  s_we = '0;

  localparam int NPTS = 30;
  localparam logic [31:0] PTS [NPTS] = '{
    32'h0000_0000, 32'h000D_FFFF, 32'h000E_0000, 32'h000F_FFFF, 32'h0010_0000,
    32'h002F_FFFF, 32'h0030_0000, 32'h0041_2345, 32'h004F_FFFF, 32'h0050_0000,
    32'h7FFF_FFFF, 32'h8000_0000, 32'h8FFF_FFFF, 32'h9000_0000, 32'h9000_0FFF,
    32'h9000_1000, 32'h9FFF_FFFF, 32'hA000_0000, 32'hA000_FFFF, 32'hFEBF_FFFF,
    32'hFEC0_0000, 32'hFEC0_0040, 32'hFEC0_0041, 32'hFECF_FFFF, 32'hFED0_0000,
    32'hFED0_03FF, 32'hFED0_0400, 32'hFFFD_FFFF, 32'hFFFE_0000, 32'hFFFF_FFFF};

  localparam int NIO = 11;
  localparam logic [31:0] IOPTS [NIO] = '{
    32'h0, 32'h0CF7, 32'h0CF8, 32'h0CFF, 32'h0D00, 32'hFFFF,
    32'h1_0000, 32'h1_0002, 32'h1_0003, 32'h1_FFFF, 32'hFFFF_FFFF};

  // expected {blocked, target[2:0], index[1:0]} from R2-R9
  function automatic logic [5:0] ref_dec(input logic io, input logic [31:0] a,
                                         input logic [2:0] ini, input logic smm);
    if (io) begin
      if (a >= 32'h0CF8 && a <= 32'h0CFF) return {1'b0, 3'd5, 2'd0};
      if (a <= 32'h1_0002) return {1'b0, 3'd4, 2'd0};
      return 6'd0;
    end
    if (s_sm_en && a[31:20] >= s_sm_lo && a[31:20] <= s_sm_hi)
      return (ini == 3'd0 && smm) ? {1'b0, 3'd1, 2'd0} : {1'b1, 3'd7, 2'd0};
    if (a >= 32'h000E_0000 && a <= 32'h000F_FFFF) return {1'b0, 3'd2, 2'd0};
    if (a >= 32'hFEC0_0000 && a <= 32'hFEC0_0040) return {1'b0, 3'd2, 2'd1};
    if (a >= 32'hFED0_0000 && a <= 32'hFED0_03FF) return {1'b0, 3'd2, 2'd2};
    if (a >= 32'hFFFE_0000) return {1'b0, 3'd2, 2'd3};
    for (int i = 0; i < 4; i++)
      if (s_we[i] && a[31:12] >= s_wb[i] && a[31:12] <= s_wl[i]) return {1'b0, 3'd3, 2'(i)};
    if (a[31:20] < s_tolm) return {1'b0, 3'd1, 2'd0};
    return 6'd0;
  endfunction

  function automatic string tag_of(input logic [5:0] e, input logic io);
    if (io) return "R9";
    if (e[5]) return "R3";
    case (e[4:2])
      3'd1: return (s_sm_en ? "R2/R7" : "R7");
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tg, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
    end
  endtask

  // R12 select map: 0 start, 1 end, 2 enable, 3 top of DRAM, 4+2i base/en, 5+2i limit
  task automatic cfg(input logic [3:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      4'd0: s_sm_lo = d[31:20];
      4'd1: s_sm_hi = d[31:20];
      4'd2: s_sm_en = d[0];
      4'd3: s_tolm  = d[31:20];
      default: begin
        if (sel[0] == 1'b0) begin s_wb[(sel-4)/2] = d[31:12]; s_we[(sel-4)/2] = d[0]; end
        else s_wl[(sel-5)/2] = d[31:12];
      end
    endcase
  endtask

  task automatic req(input logic io, input logic [31:0] a, input logic wr,
                     input logic [2:0] ini, input logic smm);
    logic [5:0] e;
    string tg;
    e = ref_dec(io, a, ini, smm);
    tg = tag_of(e, io);
    req_valid = 1'b1; req_io = io; req_addr = a; req_write = wr; req_init = ini; req_smm = smm;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", {63'd0, rsp_valid}, 64'd1, "rsp_valid");
    chk(tg, {58'd0, rsp_blocked, rsp_target, rsp_index}, {58'd0, e},
        $sformatf("decode addr=%h io=%0d init=%0d smm=%0d", a, io, ini, smm));
    chk("R11", {63'd0, rsp_write}, {63'd0, wr & ~e[5]}, "rsp_write");
    chk("R3", {32'd0, rsp_rdata}, {32'd0, {32{e[5] & ~wr}}}, "rsp_rdata");
    chk("R3", {63'd0, viol_pulse}, {63'd0, e[5]}, "viol_pulse");
    if (e[5]) chk("R3", {32'd0, viol_addr}, {32'd0, a}, "viol_addr");
  endtask

  task automatic sweep_mem();
    for (int p = 0; p < NPTS; p++)
      for (int k = 0; k < 8; k++)
        req(1'b0, PTS[p], k[0], k[1] ? 3'd2 : 3'd0, k[2]);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {63'd0, rsp_valid}, 64'd0, "rsp_valid after reset");
    chk("R1", {63'd0, viol_pulse}, 64'd0, "viol after reset");
    req(1'b0, 32'h0FFF_FFFF, 1'b0, 3'd1, 1'b0);
    req(1'b0, 32'h1000_0000, 1'b0, 3'd1, 1'b0);
    sweep_mem();

    // R4/R7 low bits ignored; R6 overlapping windows, lowest index wins
    cfg(4'd0, 32'h0030_1234);
    cfg(4'd1, 32'h004F_FFFF);
    cfg(4'd2, 32'h0000_0001);
    cfg(4'd3, 32'h8001_2345);
    cfg(4'd4, 32'h9000_0001);  cfg(4'd5, 32'h9000_0FFF);
    cfg(4'd6, 32'h9000_0001);  cfg(4'd7, 32'h9FFF_FFFF);
    cfg(4'd8, 32'hFEC0_0001);  cfg(4'd9, 32'hFECF_FFFF);
    cfg(4'd10, 32'hA000_0000); cfg(4'd11, 32'hA000_FFFF);
    sweep_mem();
    for (int q = 0; q < NIO; q++) begin
      req(1'b1, IOPTS[q], 1'b0, 3'd2, 1'b0);
      req(1'b1, IOPTS[q], 1'b1, 3'd0, 1'b1);
    end

    // R10 idle cycle
    @(negedge clk);
    chk("R10", {63'd0, rsp_valid}, 64'd0, "rsp_valid idle");
    chk("R10", {63'd0, viol_pulse}, 64'd0, "viol idle");

    // window disabled, window 3 enabled, window 1 disabled
    cfg(4'd2, 32'h0);
    cfg(4'd10, 32'hA000_0001);
    cfg(4'd6, 32'h9000_0000);
    sweep_mem();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule